// File: doc/BRIEF.md
# Serial/Parallel FIFO Input Staging Register

This block is the entry stage of a fall-through FIFO slice. It collects one word either in a single parallel capture or bit by bit from a serial line. Once a complete word is held it raises an input-full flag. A low-active transfer request then hands the word to the top of the stack, provided the stack reports that location as empty. The transfer appears as a one-cycle push strobe carrying the word. After the transfer the register returns to its starting pattern and is ready for the next word.

Fullness in serial mode is tracked by a marker bit. Initialization loads that marker at the entry end of a chain of word-width plus one flops. Each serial shift moves it one place along the chain. When it reaches the last flop, the word is complete. In an expanded row of slices, an interlock decides when a slice may re-initialize. A slice latched as master at master reset re-initializes as soon as its transfer is done. A slice latched as slave waits until its expansion-select input is driven low by the device of higher priority.

The serial clock, serial data and parallel-load inputs are brought onto the system clock through synchronizers. The other control inputs are taken to be synchronous to the system clock.

Top module: `fifo_in_stage`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `mr_n` has been sampled low, `in_full` and `push` are 0. `mr_n` does not alter the value held on `push_word`.
- R2: While the synchronized `par_load` is high, `par_d` is captured as the word, with `par_d[i]` becoming bit i, and `in_full` goes to 1.
- R3: Each high-to-low transition of `ser_clk` shifts in one bit of `ser_d`, provided `xsel_n` and `par_load` are low and the register is not full. The first bit shifted becomes bit 0 of the word, and `in_full` rises after the WORD_W-th shift.
- R4: While `in_full` is 1, further `ser_clk` falls leave the word and `in_full` unchanged.
- R5: While `xsel_n` is high, `ser_clk` falls do not shift, so `in_full` stays 0.
- R6: With `xfer_req_n` low, `in_full` high and `top_empty` high, `push` pulses for exactly one cycle with the held word on `push_word`. Holding `xfer_req_n` low never pushes the same word a second time.
- R7: While `top_empty` is low, no push occurs. The push follows once `top_empty` goes high.
- R8: After a push, re-initialization (`in_full` back to 0) waits until the synchronized `par_load` is low.
- R9: A master slice clears `in_full` in the cycle after the push strobe. A slave slice keeps `in_full` high until `xsel_n` is low.
- R10: The slice becomes master when `xsel_n` is low while `mr_n` is low, and becomes slave when `xsel_n` is high at that time.
- R11: When a parallel load and a serial shift are due in the same cycle, the parallel load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mr_n | input | 1 | Active-low master reset of the control state; latches master/slave role |
| xsel_n | input | 1 | Expansion select: low enables shifting and releases a slave's re-initialization |
| par_load | input | 1 | Level-sensitive parallel capture request (asynchronous) |
| par_d | input | WORD_W | Parallel data word |
| ser_clk | input | 1 | Serial clock, falling edge shifts (asynchronous) |
| ser_d | input | 1 | Serial data bit (asynchronous) |
| xfer_req_n | input | 1 | Active-low request to move the word into the stack |
| top_empty | input | 1 | Stack top location is free |
| in_full | output | 1 | A complete word is held |
| push | output | 1 | One-cycle strobe writing `push_word` into the stack |
| push_word | output | WORD_W | Word handed to the stack, held between pushes |

## Verification
The bench builds the block with WORD_W = 4 and SYNC_STAGES = 2. With those values a full serial word takes four falls, so the marker's arrival and the ignored fifth and sixth falls are all exercised. The two-stage synchronizer lets the reference model line up a parallel capture and a serial fall in the same cycle to test priority. Both master and slave roles are latched in turn, so the interlock's immediate re-initialization and its deferred re-initialization are each observed.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    CH_HOLD  = 2'd0,
    CH_INIT  = 2'd1,
    CH_LOAD  = 2'd2,
    CH_SHIFT = 2'd3
  } chain_op_e;
endpackage

// File: rtl/fis_rst_sync.sv
module fis_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_no
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_no = rs_q[1];
endmodule

// File: rtl/fis_sync.sv
module fis_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;
  logic [STAGES-1:0][WIDTH-1:0] st_n;

  always_comb begin
    st_n[0] = d;
    for (int i = 1; i < STAGES; i++) st_n[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/fis_chain.sv
module fis_chain
  import fis_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chain_op_e         op,
  input  logic [WORD_W-1:0] par_d,
  input  logic              ser_d,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  localparam logic [WORD_W-1:0] MARK = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] dat_q, dat_n;
  logic              fc_q, fc_n;

  always_comb begin
    dat_n = dat_q;
    fc_n  = fc_q;
    unique case (op)
      CH_INIT:  begin dat_n = MARK;  fc_n = 1'b0; end
      CH_LOAD:  begin dat_n = par_d; fc_n = 1'b1; end
      CH_SHIFT: begin dat_n = {ser_d, dat_q[WORD_W-1:1]}; fc_n = dat_q[0]; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= MARK;
      fc_q  <= 1'b0;
    end else begin
      dat_q <= dat_n;
      fc_q  <= fc_n;
    end
  end

  assign word = dat_q;
  assign full = fc_q;

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_q && op != CH_INIT) |=> fc_q);
endmodule

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import fis_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr_n,
  input  logic              xsel_n,
  input  logic              xfer_req_n,
  input  logic              top_empty,
  input  logic              pl_s,
  input  logic              ser_fall,
  input  logic              full,
  input  logic [WORD_W-1:0] word,
  output chain_op_e         op,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic              master_q, master_n;
  logic              req_q, req_n;
  logic              push_q, push_n;
  logic [WORD_W-1:0] pw_q, pw_n;
  logic              reinit_ok;
  logic              push_go;

  assign reinit_ok = req_q && !pl_s && (master_q || !xsel_n);
  assign push_go   = mr_n && !xfer_req_n && full && top_empty && !req_q;

  always_comb begin
    if (!mr_n)                             op = CH_INIT;
    else if (reinit_ok)                    op = CH_INIT;
    else if (pl_s)                         op = CH_LOAD;
    else if (ser_fall && !xsel_n && !full) op = CH_SHIFT;
    else                                   op = CH_HOLD;
  end

  always_comb begin
    master_n = master_q;
    req_n    = req_q;
    pw_n     = pw_q;
    push_n   = push_go;
    if (!mr_n) begin
      master_n = !xsel_n;
      req_n    = 1'b0;
    end else if (push_go) begin
      req_n    = 1'b1;
      pw_n     = word;
    end else if (op == CH_INIT) begin
      req_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      req_q    <= 1'b0;
      push_q   <= 1'b0;
      pw_q     <= '0;
    end else begin
      master_q <= master_n;
      req_q    <= req_n;
      push_q   <= push_n;
      pw_q     <= pw_n;
    end
  end

  assign push      = push_q;
  assign push_word = pw_q;

  // R6
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);
  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(full));
  // R1
  mr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_n |=> (!full && !push_q));
  // R8
  reinit_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(full) && $past(mr_n)) |-> $past(!pl_s));
  // R9
  slave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(full) && $past(mr_n)) |-> $past(master_q || !xsel_n));
endmodule

// File: rtl/fifo_in_stage.sv
module fifo_in_stage
  import fis_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr_n,
  input  logic              xsel_n,
  input  logic              par_load,
  input  logic [WORD_W-1:0] par_d,
  input  logic              ser_clk,
  input  logic              ser_d,
  input  logic              xfer_req_n,
  input  logic              top_empty,
  output logic              in_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  localparam int SYN_W = 3;

  logic             rst_i;
  logic [SYN_W-1:0] syn_q;
  logic             pl_s, sclk_s, sd_s;
  logic             sclk_prev_q, sclk_prev_n;
  logic             ser_fall;
  chain_op_e        op;
  logic [WORD_W-1:0] word;
  logic             full;

  fis_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_no (rst_i)
  );

  fis_sync #(.WIDTH(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({par_load, ser_clk, ser_d}),
    .q     (syn_q)
  );

  assign {pl_s, sclk_s, sd_s} = syn_q;

  assign sclk_prev_n = sclk_s;
  assign ser_fall    = sclk_prev_q && !sclk_s;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_prev_n;
  end

  fis_chain #(.WORD_W(WORD_W)) u_chain (
    .clk   (clk),
    .rst_n (rst_i),
    .op    (op),
    .par_d (par_d),
    .ser_d (sd_s),
    .word  (word),
    .full  (full)
  );

  fis_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .mr_n       (mr_n),
    .xsel_n     (xsel_n),
    .xfer_req_n (xfer_req_n),
    .top_empty  (top_empty),
    .pl_s       (pl_s),
    .ser_fall   (ser_fall),
    .full       (full),
    .word       (word),
    .op         (op),
    .push       (push),
    .push_word  (push_word)
  );

  assign in_full = full;

  // R3
  shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (op == CH_SHIFT) |-> (!xsel_n && !pl_s));
endmodule

// File: tb/test_fifo_in_stage.sv
module test_fifo_in_stage;
  localparam int W    = 4;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mr_n = 1'b1;
  logic         xsel_n = 1'b0;
  logic         par_load = 1'b0;
  logic [W-1:0] par_d = '0;
  logic         ser_clk = 1'b1;
  logic         ser_d = 1'b0;
  logic         xfer_req_n = 1'b1;
  logic         top_empty = 1'b1;
  logic         in_full;
  logic         push;
  logic [W-1:0] push_word;

  always #2 clk = ~clk;

  fifo_in_stage #(.WORD_W(W), .SYNC_STAGES(SYNC)) i_fifo_in_stage (
    .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .xsel_n(xsel_n),
    .par_load(par_load), .par_d(par_d), .ser_clk(ser_clk), .ser_d(ser_d),
    .xfer_req_n(xfer_req_n), .top_empty(top_empty),
    .in_full(in_full), .push(push), .push_word(push_word)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit q_pl [SYNC];
  bit q_sc [SYNC];
  bit q_sd [SYNC];
  bit m_prev, m_full, m_req, m_master, m_push;
  int m_cnt;
  bit [W-1:0] m_word, m_pword;

  always @(posedge clk) begin
    bit pl, sc, sd, fall, old_full, old_req, go;
    bit [W-1:0] old_word;
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) begin q_pl[i] = 0; q_sc[i] = 0; q_sd[i] = 0; end
      m_prev = 0; m_full = 0; m_req = 0; m_master = 0; m_push = 0;
      m_cnt = 0; m_word = '0; m_pword = '0;
    end else begin
      pl = q_pl[SYNC-1]; sc = q_sc[SYNC-1]; sd = q_sd[SYNC-1];
      fall = m_prev && !sc;
      m_prev = sc;
      for (int i = SYNC-1; i > 0; i--) begin
        q_pl[i] = q_pl[i-1]; q_sc[i] = q_sc[i-1]; q_sd[i] = q_sd[i-1];
      end
      q_pl[0] = par_load; q_sc[0] = ser_clk; q_sd[0] = ser_d;
      old_full = m_full; old_req = m_req; old_word = m_word;
      if (!mr_n) begin
        m_master = !xsel_n; m_req = 0; m_push = 0;
        m_full = 0; m_cnt = 0; m_word = '0;
      end else begin
        go = !xfer_req_n && old_full && top_empty && !old_req;
        if (old_req && !pl && (m_master || !xsel_n)) begin
          m_full = 0; m_cnt = 0; m_word = '0; m_req = 0;
        end else if (pl) begin
          m_word = par_d; m_full = 1; m_cnt = W;
        end else if (fall && !xsel_n && !old_full) begin
          m_word[m_cnt] = sd; m_cnt++;
          if (m_cnt == W) m_full = 1;
        end
        if (go) begin m_req = 1; m_pword = old_word; end
        m_push = go;
      end
    end
  end

  int npush = 0;
  bit [W-1:0] last_word = '0;

  always @(negedge clk) begin
    if (chk_on) begin
      chk(in_full == m_full, "R2 model in_full", in_full, m_full);
      chk(push == m_push, "R6 model push", push, m_push);
      chk(push_word == m_pword, "R6 model push_word", push_word, m_pword);
    end
    if (push) begin npush++; last_word = push_word; end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pl_pulse(input bit [W-1:0] v);
    par_d = v; par_load = 1; idle(3); par_load = 0; idle(4);
  endtask

  task automatic ser_bit(input bit b);
    ser_d = b; idle(3); ser_clk = 0; idle(3); ser_clk = 1; idle(3);
  endtask

  task automatic do_mr(input bit xs);
    xsel_n = xs; mr_n = 0; idle(2); mr_n = 1; idle(2);
  endtask

  initial begin
    int np;
    bit [W-1:0] held;
    idle(3);
    // R1 reset state
    chk(in_full == 0, "R1 in_full in reset", in_full, 0);
    chk(push == 0, "R1 push in reset", push, 0);
    rst_n = 1; idle(5);
    chk_on = 1;
    do_mr(0);   // R10 master
    chk(in_full == 0, "R1 in_full after mr", in_full, 0);

    // R2 parallel load, R7 stall, R6 push, R9 master reinit
    pl_pulse(4'hA);
    chk(in_full == 1, "R2 full after load", in_full, 1);
    np = npush;
    top_empty = 0; xfer_req_n = 0; idle(6);
    chk(npush == np, "R7 no push while top busy", npush, np);
    top_empty = 1; idle(8);
    chk(npush == np + 1, "R6 single push", npush, np + 1);
    chk(last_word == 4'hA, "R2 pushed word", last_word, 4'hA);
    chk(in_full == 0, "R9 master reinit", in_full, 0);
    xfer_req_n = 1; idle(2);

    // R3 serial entry, R4 extra falls ignored
    ser_bit(1); ser_bit(0); ser_bit(1);
    chk(in_full == 0, "R3 not full after 3 bits", in_full, 0);
    ser_bit(1);
    chk(in_full == 1, "R3 full after 4 bits", in_full, 1);
    ser_bit(0); ser_bit(0);
    chk(in_full == 1, "R4 still full", in_full, 1);
    np = npush;
    xfer_req_n = 0; idle(6); xfer_req_n = 1; idle(2);
    chk(npush == np + 1, "R3 serial push", npush, np + 1);
    chk(last_word == 4'hD, "R4 serial word intact", last_word, 4'hD);

    // R5 serial blocked by xsel_n high
    xsel_n = 1;
    ser_bit(1); ser_bit(1); ser_bit(1); ser_bit(1);
    chk(in_full == 0, "R5 no shift with xsel_n high", in_full, 0);
    xsel_n = 0; idle(2);

    // R8 reinit deferred while par_load high
    np = npush;
    par_d = 4'h5; par_load = 1; xfer_req_n = 0; idle(10);
    chk(npush == np + 1, "R8 one push while load held", npush, np + 1);
    chk(in_full == 1, "R8 full held while load high", in_full, 1);
    par_load = 0; idle(5);
    chk(in_full == 0, "R8 reinit after load low", in_full, 0);
    xfer_req_n = 1; idle(2);

    // R11 load beats simultaneous serial fall
    ser_d = 1; idle(3);
    par_d = 4'h3; ser_clk = 0; par_load = 1; idle(3);
    par_load = 0; ser_clk = 1; idle(4);
    chk(in_full == 1, "R11 full after collision", in_full, 1);
    xfer_req_n = 0; idle(6); xfer_req_n = 1; idle(2);
    chk(last_word == 4'h3, "R11 parallel word wins", last_word, 4'h3);

    // R10 slave, R9 deferred reinit, R1 word kept across mr
    held = push_word;
    do_mr(1);
    chk(push_word == held, "R1 mr keeps push_word", push_word, held);
    pl_pulse(4'h6);
    np = npush;
    xfer_req_n = 0; idle(8);
    chk(npush == np + 1, "R10 slave push", npush, np + 1);
    chk(in_full == 1, "R9 slave waits", in_full, 1);
    xsel_n = 0; idle(3);
    chk(in_full == 0, "R9 slave reinit on xsel_n low", in_full, 0);
    xfer_req_n = 1; idle(2);

    // R1 master reset while full
    do_mr(0);
    pl_pulse(4'h9);
    chk(in_full == 1, "R2 full before mr", in_full, 1);
    do_mr(0);
    chk(in_full == 0, "R1 mr clears full", in_full, 0);
    idle(4);

    chk_on = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule